// File: doc/BRIEF.md
# Chatter-Tolerant Rotary Knob Decoder

This block turns the raw contacts of a mechanical rotary knob into clean step events. The knob has two quadrature contacts and a push-button shaft. Each quadrature contact reads 1 when it is open and 0 when it is closed. At a rest (detent) position both contacts are closed. Turning the knob clockwise opens A before B. Turning it counter-clockwise opens B before A. The push contact reads 1 while the shaft is pressed, and it bounces for a few milliseconds.

All three inputs are asynchronous. Each one is synchronized and then filtered by a stability counter: a new level is accepted only after it has held for `STABLE_CYCLES` clocks, which defaults to about 1 ms at 50 MHz. Two hysteresis flags are built from the filtered A and B. A flag rising edge produces one step per detent, with a direction bit. A signed wrapping position counter follows the steps. The debounced press level is output, together with a one-cycle pulse on each accepted press.

Top module: `knob_decoder`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `step_valid`, `press_level` and `press_pulse` are 0 and `position` is 0.
- R2: A change on the A or B contact that lasts fewer than `STABLE_CYCLES` clocks produces no step and leaves `position` unchanged.
- R3: The contact sequence (A,B) = 00, 10, 11, 01, 00, with each state held longer than the filter window, produces exactly one `step_valid` pulse with `step_dir` = 1 (clockwise) and adds 1 to `position`.
- R4: The sequence 00, 01, 11, 10, 00 produces exactly one `step_valid` pulse with `step_dir` = 0 (counter-clockwise) and subtracts 1 from `position`.
- R5: Once both contacts are open (11), moving between 11 and a single-open state any number of times produces no further step until both contacts have closed again (00).
- R6: `step_valid` is never high on two consecutive cycles.
- R7: `position` is an 8-bit two's-complement count that wraps from 127 to -128 on a clockwise step and from -128 to 127 on a counter-clockwise step.
- R8: `position` changes only in the cycle after a `step_valid` pulse.
- R9: `press_level` follows the push input only after the input has held a new level for `STABLE_CYCLES` clocks. Shorter pulses are ignored.
- R10: `press_pulse` is high for exactly one cycle on each accepted rising edge of `press_level`, and never on a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| knob_a | input | 1 | Quadrature contact A, asynchronous, 1 = open |
| knob_b | input | 1 | Quadrature contact B, asynchronous, 1 = open |
| knob_push | input | 1 | Shaft push contact, asynchronous, 1 = pressed |
| step_valid | output | 1 | One-cycle pulse per detent step |
| step_dir | output | 1 | Direction, valid with step_valid: 1 = clockwise, 0 = counter-clockwise |
| position | output | 8 | Signed wrapping step count |
| press_level | output | 1 | Debounced push level |
| press_pulse | output | 1 | One-cycle pulse on each accepted press |

## Verification
The bench drives glitches on A, B and the push contact that are shorter than the filter window. A design with a missing or too short filter would count these as steps or presses. It repeats the 11-to-10 bounce several times within one detent, which a decoder without hysteresis would report as several clicks or as a reversed click. It walks the position across the 127/-128 boundary in both directions, where saturating or sign-extension mistakes would show. It also releases the push button to confirm that no pulse fires on the falling edge.

// File: rtl/knob_pkg.sv
// Package: shared definitions for the rotary knob decoder.
// Assumes: the step direction is a single bit and the position is two's complement.
package knob_pkg;
    typedef enum logic {
        DIR_CCW = 1'b0,
        DIR_CW  = 1'b1
    } knob_dir_e;

    localparam int KNOB_INPUTS = 3;   // A, B, push
    localparam int IDX_A       = 0;
    localparam int IDX_B       = 1;
    localparam int IDX_PUSH    = 2;
endpackage

// File: rtl/knob_sync.sv
// Module: two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; no bus coherence is needed across bits.
module knob_sync #(
    parameter int                WIDTH   = 3,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta;

    // Purpose: two register stages to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            dout <= RST_VAL;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/knob_filter.sv
// Module: stability-counter filter for one synchronized contact.
// Accepts a new level only after it has differed from the held level
// for STABLE_CYCLES consecutive clocks. Any return to the held level
// restarts the count.
// Assumes: din is already synchronous to clk.
module knob_filter #(
    parameter int   STABLE_CYCLES = 50000,
    parameter logic RST_VAL       = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: count cycles of disagreement and commit after a full window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= RST_VAL;
            cnt  <= '0;
        end else if (din == dout) begin
            cnt  <= '0;
        end else if (cnt == CNT_LAST) begin
            dout <= din;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // The filtered level only ever moves to the value the input presented.
    AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> dout == $past(din));  // R2
endmodule

// File: rtl/knob_quad.sv
// Module: detent decoder with hysteresis flags and a position counter.
// both_open sets at AB=11 and clears at AB=00. a_first sets at AB=10
// and clears at AB=01. A rising both_open gives one step. The step
// direction is a_first at that instant: A opened first means clockwise.
// Assumes: a and b are filtered and synchronous; detent is AB=00.
module knob_quad #(
    parameter int POS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a,
    input  logic                    b,
    output logic                    step_valid,
    output logic                    step_dir,
    output logic signed [POS_W-1:0] position
);
    import knob_pkg::*;

    logic both_open, both_open_d, a_first;

    // Purpose: hysteresis flags that change only at the defining states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_open   <= 1'b0;
            a_first     <= 1'b0;
            both_open_d <= 1'b0;
        end else begin
            both_open_d <= both_open;
            if (a && b)        both_open <= 1'b1;
            else if (!a && !b) both_open <= 1'b0;
            if (a && !b)       a_first <= 1'b1;
            else if (!a && b)  a_first <= 1'b0;
        end
    end

    assign step_valid = both_open && !both_open_d;
    assign step_dir   = a_first ? DIR_CW : DIR_CCW;

    // Purpose: wrapping signed count of accepted steps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            position <= '0;
        else if (step_valid)
            position <= (step_dir == DIR_CW) ? position + 1'b1 : position - 1'b1;
    end

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !step_valid);  // R6
    AST_POS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(position));  // R8
    AST_POS_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> position != $past(position));  // R8
endmodule

// File: rtl/knob_decoder.sv
// Module: top of the rotary knob decoder.
// Synchronizes the three contacts, filters each one and decodes the
// quadrature pair. It also debounces the push contact and makes a
// press pulse.
// Assumes: single clock, synchronous active-low reset, detent at AB=00.
module knob_decoder #(
    parameter int STABLE_CYCLES = 50000,
    parameter int POS_W         = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    knob_a,
    input  logic                    knob_b,
    input  logic                    knob_push,
    output logic                    step_valid,
    output logic                    step_dir,
    output logic signed [POS_W-1:0] position,
    output logic                    press_level,
    output logic                    press_pulse
);
    import knob_pkg::*;

    logic [KNOB_INPUTS-1:0] raw, synced, filt;
    logic                   press_d;

    assign raw[IDX_A]    = knob_a;
    assign raw[IDX_B]    = knob_b;
    assign raw[IDX_PUSH] = knob_push;

    knob_sync #(.WIDTH(KNOB_INPUTS), .RST_VAL('0)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
    );

    for (genvar i = 0; i < KNOB_INPUTS; i++) begin : g_filt
        knob_filter #(.STABLE_CYCLES(STABLE_CYCLES), .RST_VAL(1'b0)) u_filt (
            .clk(clk), .rst_n(rst_n), .din(synced[i]), .dout(filt[i])
        );
    end

    knob_quad #(.POS_W(POS_W)) u_quad (
        .clk(clk), .rst_n(rst_n),
        .a(filt[IDX_A]), .b(filt[IDX_B]),
        .step_valid(step_valid), .step_dir(step_dir), .position(position)
    );

    assign press_level = filt[IDX_PUSH];

    // Purpose: previous press level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) press_d <= 1'b0;
        else        press_d <= press_level;
    end

    assign press_pulse = press_level && !press_d;

    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse);  // R10
    AST_PRESS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> press_level);  // R10
endmodule

// File: tb/sim_knob_decoder.sv
// Directed bench for knob_decoder with a short filter window.
module sim_knob_decoder;
    localparam int CLK_PERIOD = 20;
    localparam int WIN        = 8;
    localparam int HOLD       = WIN + 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic knob_a = 1'b0, knob_b = 1'b0, knob_push = 1'b0;
    logic step_valid, step_dir, press_level, press_pulse;
    logic signed [7:0] position;

    int checks = 0, errors = 0;
    int cw_cnt = 0, ccw_cnt = 0, press_cnt = 0, double_step = 0;
    logic prev_step = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    knob_decoder #(.STABLE_CYCLES(WIN), .POS_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .knob_a(knob_a), .knob_b(knob_b),
        .knob_push(knob_push), .step_valid(step_valid), .step_dir(step_dir),
        .position(position), .press_level(press_level), .press_pulse(press_pulse)
    );

    // Event counters read on the clock edge before outputs update.
    always @(posedge clk) begin
        if (rst_n) begin
            if (step_valid && step_dir)  cw_cnt++;
            if (step_valid && !step_dir) ccw_cnt++;
            if (step_valid && prev_step) double_step++;
            if (press_pulse)             press_cnt++;
            prev_step <= step_valid;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ab(input logic a, input logic b);
        @(negedge clk);
        knob_a = a; knob_b = b;
        wait_cyc(HOLD);
    endtask

    task automatic turn_cw();
        set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    endtask

    task automatic turn_ccw();
        set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 step_valid", step_valid, 0);
        check("R1 position", position, 0);
        check("R1 press_level", press_level, 0);
        check("R1 press_pulse", press_pulse, 0);
    endtask

    task automatic t_glitch();
        int c0 = cw_cnt, c1 = ccw_cnt;
        @(negedge clk); knob_a = 1; wait_cyc(WIN - 3); knob_a = 0; wait_cyc(HOLD);
        @(negedge clk); knob_b = 1; wait_cyc(WIN - 3); knob_b = 0; wait_cyc(HOLD);
        check("R2 glitch steps", (cw_cnt - c0) + (ccw_cnt - c1), 0);
        check("R2 glitch position", position, 0);
    endtask

    task automatic t_cw();
        int c0 = cw_cnt, c1 = ccw_cnt, p0 = position;
        turn_cw();
        check("R3 cw steps", cw_cnt - c0, 1);
        check("R3 no ccw", ccw_cnt - c1, 0);
        check("R3 position", position, p0 + 1);
    endtask

    task automatic t_ccw();
        int c0 = cw_cnt, c1 = ccw_cnt, p0 = position;
        turn_ccw();
        check("R4 ccw steps", ccw_cnt - c1, 1);
        check("R4 no cw", cw_cnt - c0, 0);
        check("R4 position", position, p0 - 1);
    endtask

    task automatic t_bounce();
        int c0 = cw_cnt, c1 = ccw_cnt;
        set_ab(1, 0); set_ab(1, 1);
        for (int i = 0; i < 3; i++) begin set_ab(1, 0); set_ab(1, 1); end
        set_ab(0, 1); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
        check("R5 bounce cw", cw_cnt - c0, 1);
        check("R5 bounce ccw", ccw_cnt - c1, 0);
        check("R6 no double step", double_step, 0);
    endtask

    task automatic t_wrap();
        int p0 = position;
        for (int i = 0; i < 127 - p0; i++) turn_cw();
        check("R7 reach max", position, 127);
        turn_cw();
        check("R7 wrap up", position, -128);
        turn_ccw();
        check("R7 wrap down", position, 127);
        wait_cyc(HOLD);
        check("R8 position idle", position, 127);
    endtask

    task automatic t_press();
        int n0 = press_cnt;
        @(negedge clk); knob_push = 1; wait_cyc(WIN - 3); knob_push = 0; wait_cyc(HOLD);
        check("R9 short press ignored", press_level, 0);
        check("R10 no pulse on glitch", press_cnt - n0, 0);
        @(negedge clk); knob_push = 1; wait_cyc(WIN - 1);
        check("R9 not yet accepted", press_level, 0);
        wait_cyc(HOLD);
        check("R9 press accepted", press_level, 1);
        check("R10 one pulse", press_cnt - n0, 1);
        @(negedge clk); knob_push = 0; wait_cyc(HOLD);
        check("R9 release", press_level, 0);
        check("R10 none on release", press_cnt - n0, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(4);
        check("R1 in reset step_valid", step_valid, 0);
        check("R1 in reset position", position, 0);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_glitch();
        t_cw();
        t_ccw();
        t_bounce();
        t_wrap();
        t_press();
        check("R6 no double step", double_step, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule